// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

This block turns a 32.768 kHz clock-enable into the periodic timing signals of a real-time clock. A binary divider chain is built from an eight-step prescaler followed by two sixty-four-step stages, which together form one 15-bit count. A 4-bit rate code picks one bit of that count as the active tap. The active tap drives a square-wave pin, which is gated by an enable input and by a power-fail input. The tap's rising edge also produces a one-cycle periodic pulse that a flag register elsewhere latches.

The most significant bit of the chain gives a one-cycle tick once per second, and that tick starts each calendar update. A 3-bit divider-control input either clears and holds the chain, lets it run, or freezes it at its current count. After a clear is released, the first second tick comes half a second later. The rate-code map is not monotonic. The two lowest non-zero codes reuse taps that higher codes also reach, and code 3 selects the fastest tap.

Top module: `rtc_rate_gen`

## Requirements
- R1: `sec_tick` is a one-cycle pulse raised at each rising edge of chain bit 14. After a clear is released it comes 16384 enabled steps later (half a second), and then every 32768 steps.
- R2: The chain advances by one only on clock cycles with `tick_en` high. Cycles with `tick_en` low do not change any output timing.
- R3: With `rate_sel` = 0 no periodic pulse is produced and `sqw_out` stays low.
- R4: For `rate_sel` = c in 3..15 the tap is chain bit c-2 (8.192 kHz down to 2 Hz). After release the first periodic pulse comes 2^(c-2) steps later and the next one comes 2^(c-1) steps after that.
- R5: `rate_sel` = 1 selects bit 6 (256 Hz) and `rate_sel` = 2 selects bit 7 (128 Hz), giving the same timing as codes 8 and 9.
- R6: `pi_pulse` is high for exactly one cycle per period. It is produced whatever the value of `sqw_en` and `pwr_fail`.
- R7: `sqw_out` equals the selected tap bit (rising together with `pi_pulse`) only while `sqw_en` = 1 and `pwr_fail` = 0. Otherwise it is low.
- R8: `div_ctl` = 11x (bits 2 and 1 both set) clears the chain to zero and holds it there. No pulse, no tick, and `sqw_out` stays low.
- R9: `div_ctl` = 010 runs the chain. Any other value outside 11x freezes the count without clearing it, and running resumes from that count.
- R10: While `rst_n` is low, all three outputs are low and the chain is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz step rate |
| rate_sel | input | SEL_W | Rate code choosing the tap |
| div_ctl | input | 3 | Divider control: 010 run, 11x clear and hold, others freeze |
| sqw_en | input | 1 | Square-wave output enable |
| pwr_fail | input | 1 | Forces the square wave low when high |
| sqw_out | output | 1 | Square-wave output |
| pi_pulse | output | 1 | One-cycle periodic pulse at the selected rate |
| sec_tick | output | 1 | One-cycle pulse starting each calendar update |

## Verification
The bench walks every rate code from a fresh release. It checks the delay to the first periodic pulse and to the second, which catches a tap map that is off by one bit and an alias code that was mapped as if the map were monotonic. Further cases check the following:
- With the enable gated to every other cycle, the pulse spacing must stretch in step; a design that counted clocks instead of steps keeps the ungated spacing.
- A frozen chain must resume from the stored count; a design that cleared the chain on freeze would move the next pulse.
- The half-second delay to the first second tick, which a design that took its tick from the wrap of the count would miss.
- That the square wave stays low under a disable or a power fail while the pulses continue.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

   // divider-control encodings
   localparam int          DCTL_W    = 3;
   localparam logic [2:0]  DCTL_RUN  = 3'b010;
   localparam logic [1:0]  DCTL_CLR2 = 2'b11;   // upper two bits

   // rate-code map anchors
   localparam int RATE_CODE_W = 4;
   localparam int FAST_CODE   = 3;   // fastest tap
   localparam int FAST_TAP    = 1;
   localparam int ALIAS_LO    = 1;   // code 1 reuses code 8's tap
   localparam int ALIAS_HI    = 2;   // code 2 reuses code 9's tap
   localparam int ALIAS_BASE  = 8;

   function automatic int rate_tap(input logic [RATE_CODE_W-1:0] code);
      int c;
      c = int'(code);
      if (c == ALIAS_LO || c == ALIAS_HI)
         return ALIAS_BASE + (c - ALIAS_LO) - FAST_CODE + FAST_TAP;
      else if (c >= FAST_CODE)
         return c - FAST_CODE + FAST_TAP;
      else
         return 0;
   endfunction

   function automatic logic ctl_clear(input logic [DCTL_W-1:0] ctl);
      return ctl[DCTL_W-1 -: 2] == DCTL_CLR2;
   endfunction

   function automatic logic ctl_run(input logic [DCTL_W-1:0] ctl);
      return ctl == DCTL_RUN;
   endfunction

endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
   import rtc_rate_pkg::*;
#(
   parameter int PRE_W = 3,
   parameter int MID_W = 6,
   parameter int N_MID = 2,
   localparam int CNT_W = PRE_W + MID_W * N_MID
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [DCTL_W-1:0] div_ctl,
   output logic [CNT_W-1:0] cnt,
   output logic             step
);

   localparam int N_STG = N_MID + 1;

   logic clr;
   logic [N_STG:0] carry;

   assign clr      = ctl_clear(div_ctl);
   assign step     = tick_en & ctl_run(div_ctl);
   assign carry[0] = step;

   for (genvar s = 0; s < N_STG; s++) begin : g_stg
      localparam int W  = (s == 0) ? PRE_W : MID_W;
      localparam int LO = (s == 0) ? 0 : PRE_W + (s - 1) * MID_W;
      logic [W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= '0;
         else if (clr)      q <= '0;
         else if (carry[s]) q <= q + 1'b1;
      end

      assign carry[s+1]   = carry[s] & (&q);
      assign cnt[LO +: W] = q;
   end

   logic unused_carry;
   assign unused_carry = carry[N_STG];

endmodule

// File: rtl/rtc_tap_edge.sv
module rtc_tap_edge #(
   parameter int CNT_W = 15
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             step,
   output logic [CNT_W-1:0] rise,
   output logic [CNT_W-1:0] nxt
);

   logic [CNT_W-1:0] ones;   // ones[i]: step and all bits below i set

   assign ones[0] = step;

   for (genvar i = 0; i < CNT_W; i++) begin : g_bit
      if (i < CNT_W - 1) begin : g_prop
         assign ones[i+1] = ones[i] & cnt[i];
      end
      assign rise[i] = ones[i] & ~cnt[i];
      assign nxt[i]  = cnt[i] ^ ones[i];
   end

endmodule

// File: rtl/rtc_rate_mux.sv
module rtc_rate_mux
   import rtc_rate_pkg::*;
#(
   parameter int CNT_W = 15,
   parameter int SEL_W = 4,
   localparam int IDX_W = $clog2(CNT_W)
) (
   input  logic [SEL_W-1:0] rate_sel,
   input  logic [CNT_W-1:0] rise,
   input  logic [CNT_W-1:0] nxt,
   output logic             active,
   output logic             tap_rise,
   output logic             tap_lvl
);

   logic [IDX_W-1:0] idx;

   always_comb begin
      idx      = IDX_W'(rate_tap(RATE_CODE_W'(rate_sel)));
      active   = |rate_sel;
      tap_rise = active & rise[idx];
      tap_lvl  = active & nxt[idx];
   end

endmodule

// File: rtl/rtc_rate_gen.sv
module rtc_rate_gen
   import rtc_rate_pkg::*;
#(
   parameter int PRE_W = 3,
   parameter int MID_W = 6,
   parameter int N_MID = 2,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [SEL_W-1:0] rate_sel,
   input  logic [2:0]       div_ctl,
   input  logic             sqw_en,
   input  logic             pwr_fail,
   output logic             sqw_out,
   output logic             pi_pulse,
   output logic             sec_tick
);

   localparam int CNT_W = PRE_W + MID_W * N_MID;

   if (SEL_W != RATE_CODE_W) begin : g_bad_sel
      $error("rtc_rate_gen: SEL_W must equal the rate-code width");
   end
   if (CNT_W < 15) begin : g_bad_chain
      $error("rtc_rate_gen: chain must be at least 15 bits");
   end

   logic [CNT_W-1:0] cnt, rise, nxt;
   logic             step, active, tap_rise, tap_lvl;

   rtc_div_chain #(.PRE_W(PRE_W), .MID_W(MID_W), .N_MID(N_MID)) u_chain (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .div_ctl(div_ctl),
      .cnt(cnt), .step(step)
   );

   rtc_tap_edge #(.CNT_W(CNT_W)) u_edge (
      .cnt(cnt), .step(step), .rise(rise), .nxt(nxt)
   );

   rtc_rate_mux #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_mux (
      .rate_sel(rate_sel), .rise(rise), .nxt(nxt),
      .active(active), .tap_rise(tap_rise), .tap_lvl(tap_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sqw_out  <= 1'b0;
         pi_pulse <= 1'b0;
         sec_tick <= 1'b0;
      end else begin
         pi_pulse <= tap_rise;
         sec_tick <= rise[CNT_W-1];
         sqw_out  <= active & sqw_en & ~pwr_fail & tap_lvl;
      end
   end

endmodule

// File: rtl/rtc_rate_gen_chk.sv
module rtc_rate_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] rate_sel,
   input logic [2:0] div_ctl,
   input logic       sqw_en,
   input logic       pwr_fail,
   input logic       sqw_out,
   input logic       pi_pulse,
   input logic       sec_tick
);

   logic hold;
   assign hold = (div_ctl[2:1] == 2'b11);

   // R1
   sec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pi_pulse |=> !pi_pulse);

   // R3
   off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 4'd0) |=> !pi_pulse && !sqw_out);

   // R7
   sqw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sqw_en || pwr_fail) |=> !sqw_out);

   // R8
   hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !pi_pulse && !sec_tick);

   // R8
   hold_sqw_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold && $past(hold) |=> !sqw_out);

   // R9
   freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_ctl != 3'b010) |=> !pi_pulse && !sec_tick);

endmodule

bind rtc_rate_gen rtc_rate_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .div_ctl(div_ctl),
   .sqw_en(sqw_en), .pwr_fail(pwr_fail), .sqw_out(sqw_out),
   .pi_pulse(pi_pulse), .sec_tick(sec_tick)
);

// File: tb/tb_rtc_rate_gen.sv
module tb_rtc_rate_gen;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [3:0] rate_sel = 4'd0;
   logic [2:0] div_ctl = 3'b110;
   logic       sqw_en = 1'b0;
   logic       pwr_fail = 1'b0;
   logic       sqw_out, pi_pulse, sec_tick;

   int n_vec = 0;
   int n_bad = 0;

   // steps from release to first pulse, indexed by rate code
   localparam int HALF_TAB [16] = '{0, 64, 128, 2, 4, 8, 16, 32,
                                    64, 128, 256, 512, 1024, 2048, 4096, 8192};

   rtc_rate_gen dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
      .div_ctl(div_ctl), .sqw_en(sqw_en), .pwr_fail(pwr_fail),
      .sqw_out(sqw_out), .pi_pulse(pi_pulse), .sec_tick(sec_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // results of one run
   int r_first, r_second, r_pulses, r_sqw_hi, r_sqw_edge, r_wide;
   int r_sec1, r_sec2, r_secs;

   // observe for 'limit' edges; edge k steps only if gate is off or k is odd
   task automatic observe(input bit gate, input int limit, input int n0);
      bit prev_pf, prev_sqw;
      prev_pf = 1'b0; prev_sqw = sqw_out;
      for (int n = n0; n <= limit; n++) begin
         @(negedge clk);
         if (pi_pulse) begin
            r_pulses++;
            if (r_first == 0) begin
               r_first = n;
               r_sqw_edge = (sqw_out && !prev_sqw) ? 1 : 0;
            end else if (r_second == 0) r_second = n;
         end
         if (sec_tick) begin
            r_secs++;
            if (r_sec1 == 0) r_sec1 = n; else if (r_sec2 == 0) r_sec2 = n;
         end
         if (pi_pulse && prev_pf) r_wide++;
         if (sqw_out) r_sqw_hi++;
         prev_pf = pi_pulse; prev_sqw = sqw_out;
         tick_en = gate ? ((n + 1) % 2 == 1) : 1'b1;
      end
   endtask

   task automatic clear_res();
      r_first = 0; r_second = 0; r_pulses = 0; r_sqw_hi = 0; r_sqw_edge = 0;
      r_wide = 0; r_sec1 = 0; r_sec2 = 0; r_secs = 0;
   endtask

   task automatic run_case(input int code, input bit gate, input logic [2:0] ctl,
                           input bit en, input bit pf, input int limit);
      @(negedge clk);
      div_ctl = 3'b110; tick_en = 1'b1;
      repeat (3) @(negedge clk);
      rate_sel = code[3:0]; sqw_en = en; pwr_fail = pf;
      div_ctl = ctl; tick_en = 1'b1;
      clear_res();
      observe(gate, limit, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      // R10: outputs stay low in reset even with a running setup
      rate_sel = 4'd3; sqw_en = 1'b1; div_ctl = 3'b010; tick_en = 1'b1;
      begin
         int seen;
         seen = 0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sqw_out || pi_pulse || sec_tick) seen++;
         end
         chk("R10 outputs during reset", seen, 0);
      end
      @(negedge clk); rst_n = 1'b1;

      // R3 R4 R5 R7: table of every rate code, square wave enabled
      for (int c = 0; c < 16; c++) begin
         int h;
         h = HALF_TAB[c];
         run_case(c, 1'b0, 3'b010, 1'b1, 1'b0, (h == 0) ? 200 : 3 * h + 1);
         if (h == 0) begin
            chk($sformatf("R3 code0 pulses"), r_pulses, 0);
            chk($sformatf("R3 code0 sqw high cycles"), r_sqw_hi, 0);
         end else begin
            chk($sformatf("R4 R5 code%0d first pulse", c), r_first, h);
            chk($sformatf("R4 R5 code%0d second pulse", c), r_second, 3 * h);
            chk($sformatf("R7 code%0d sqw rises with pulse", c), r_sqw_edge, 1);
            chk($sformatf("R6 code%0d pulse width", c), r_wide, 0);
         end
      end

      // R2: enable on every other cycle stretches the spacing
      run_case(3, 1'b1, 3'b010, 1'b1, 1'b0, 12);
      chk("R2 gated first pulse", r_first, 3);
      chk("R2 gated second pulse", r_second, 11);

      // R6 R7: disabled square wave, pulses continue
      run_case(4, 1'b0, 3'b010, 1'b0, 1'b0, 13);
      chk("R6 pulses with sqw disabled", r_pulses, 2);
      chk("R7 sqw low when disabled", r_sqw_hi, 0);

      // R7: power fail forces the square wave low
      run_case(4, 1'b0, 3'b010, 1'b1, 1'b1, 13);
      chk("R6 pulses under power fail", r_pulses, 2);
      chk("R7 sqw low under power fail", r_sqw_hi, 0);

      // R8: clear-and-hold keeps everything quiet
      run_case(3, 1'b0, 3'b111, 1'b1, 1'b0, 60);
      chk("R8 hold pulses", r_pulses + r_secs, 0);
      chk("R8 hold sqw", r_sqw_hi, 0);

      // R9: freeze then resume from the stored count
      run_case(3, 1'b0, 3'b010, 1'b1, 1'b0, 5);   // count now 5
      div_ctl = 3'b000;
      clear_res();
      observe(1'b0, 50, 1);
      chk("R9 frozen pulses", r_pulses, 0);
      chk("R9 frozen sqw high cycles", r_sqw_hi, 0);
      div_ctl = 3'b010;
      clear_res();
      observe(1'b0, 4, 1);
      chk("R9 resume first pulse", r_first, 1);

      // R1: half second to the first tick, then one second
      run_case(0, 1'b0, 3'b010, 1'b0, 1'b0, 49153);
      chk("R1 first second tick", r_sec1, 16384);
      chk("R1 second second tick", r_sec2, 49152);
      chk("R1 tick count", r_secs, 2);

      report();
   end

endmodule